// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

A 16-bit up-counter runs on every clock. An 8-bit processor reads it through a byte-wide register port. The high byte and the low byte of the count come from two separate reads, so the block makes the pair coherent. When software reads a high-byte register, the block captures the low byte into a holding buffer. The next read of the matching low-byte register returns that held value. There are two independent read pairs, main and alternate. Each pair has its own buffer and its own pending state.

When the count wraps from all-ones to zero, the block sets an overflow flag. This flag drives an interrupt request, which is gated by an enable bit and by an external global mask. Software clears the flag in two steps: it reads the status register while the flag is set, and then it accesses the main low-byte register. Accesses to the alternate pair never clear the flag, so software can sample elapsed time through the alternate pair without disturbing overflow handling.

A halt input freezes the counter. A wait input has no effect on counting.

Top module: `byte_read_timer`

## Requirements
- R1: After reset the count is FFFCh. The overflow flag is 0, the control byte is 00h and `irqOut` is 0.
- R2: When `haltIn` is 0, the count increments by one on every clock edge. It wraps from FFFFh to 0000h. `waitIn` has no effect on counting.
- R3: While `haltIn` is 1, the count holds its value, and counting resumes from that value when `haltIn` returns to 0. A reset applied during halt reloads FFFCh.
- R4: A read of address 0 (main high) or address 2 (alternate high) returns bits 15:8 of the count. If that pair has no read pending, the same read captures bits 7:0 into the pair's buffer and marks a read as pending.
- R5: While a pair has a read pending, further high-byte reads of that pair leave its buffer unchanged. A read of the pair's low register (address 1 main, address 3 alternate) returns the buffered byte and ends the pending state.
- R6: A low-register read with no read pending on that pair returns the live bits 7:0 of the count.
- R7: The main and alternate pairs keep separate buffers and pending states, so interleaved sequences on the two pairs do not disturb each other.
- R8: The overflow flag is set on the edge where the count wraps from FFFFh to 0000h. It reads as bit 0 of address 4, and the other bits of address 4 read 0.
- R9: `irqOut` is 1 exactly when the flag is 1, bit 0 of the control byte is 1 and `irqMaskIn` is 0. A request that is blocked by the enable or by the mask stays pending until both allow it.
- R10: The flag clears only after two steps: a read of address 4 that sees the flag set, followed by a read or write of address 1. A status read that sees the flag at 0 arms nothing. A wrap between the two steps keeps the flag set.
- R11: Reads or writes of addresses 2 and 3 never clear the overflow flag and never break an armed clear sequence.
- R12: A write to address 1 loads the count with FFFCh on that edge, whatever the value of `haltIn`.
- R13: A write to address 5 stores the byte as the control byte. Address 5 reads it back. Reads of addresses 6 and 7 return 00h, and writes to addresses other than 1 and 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdEn | input | 1 | Register read strobe for this cycle |
| wrEn | input | 1 | Register write strobe for this cycle |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irqMaskIn | input | 1 | Global interrupt mask, 1 blocks the request |
| haltIn | input | 1 | Halt request, freezes the counter |
| waitIn | input | 1 | Wait mode indication, does not affect counting |
| irqOut | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 3-bit address and a reset count of FFFCh. Because the reset count is FFFCh, a wrap comes four cycles after reset or after any write to the main low register. This lets the bench check flag setting, the clear sequence and the interrupt gating many times in a short run. One scenario leaves the counter free for a full 65536-cycle period between the two clear steps. It shows that a wrap after the status read keeps the flag.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MAIN_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAIN_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_ALT_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALT_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd5;

  typedef struct packed {
    logic rdMainHi;
    logic rdMainLo;
    logic rdAltHi;
    logic rdAltLo;
    logic wrMainLo;
    logic rdStatus;
    logic wrCtrl;
  } strobe_t;
endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqMaskIn,
  input  logic              wrapPulse,
  output strobe_t           strb,
  output logic              flag,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              irqOut
);
  logic armed;
  logic mainLoAccess;

  always_comb begin
    strb.rdMainHi = rdEn && (addr == A_MAIN_HI);
    strb.rdMainLo = rdEn && (addr == A_MAIN_LO);
    strb.rdAltHi  = rdEn && (addr == A_ALT_HI);
    strb.rdAltLo  = rdEn && (addr == A_ALT_LO);
    strb.wrMainLo = wrEn && (addr == A_MAIN_LO);
    strb.rdStatus = rdEn && (addr == A_STATUS);
    strb.wrCtrl   = wrEn && (addr == A_CTRL);
  end

  assign mainLoAccess = strb.rdMainLo || strb.wrMainLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag    <= 1'b0;
      armed   <= 1'b0;
      ctrlReg <= '0;
    end else begin
      if (wrapPulse) begin
        flag  <= 1'b1;
        armed <= 1'b0;
      end else if (mainLoAccess) begin
        if (armed) flag <= 1'b0;
        armed <= 1'b0;
      end else if (strb.rdStatus && flag) begin
        armed <= 1'b1;
      end
      if (strb.wrCtrl) ctrlReg <= wrData;
    end
  end

  assign irqOut = flag && ctrlReg[0] && !irqMaskIn;
endmodule

// File: rtl/brt_datapath.sv
module brt_datapath
  import brt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 2 * DATA_W,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltIn,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flag,
  input  logic [DATA_W-1:0] ctrlReg,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrapPulse,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned NPAIR = 2;

  logic [NPAIR-1:0]              pend;
  logic [NPAIR-1:0][DATA_W-1:0]  lowBuf;
  logic [NPAIR-1:0]              hiRd;
  logic [NPAIR-1:0]              loRd;
  logic [NPAIR-1:0][DATA_W-1:0]  loView;

  assign hiRd = {strb.rdAltHi, strb.rdMainHi};
  assign loRd = {strb.rdAltLo, strb.rdMainLo};

  assign wrapPulse = !haltIn && !strb.wrMainLo && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= RESET_VAL;
    else if (strb.wrMainLo) cnt <= RESET_VAL;
    else if (!haltIn)       cnt <= cnt + 1'b1;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend[p]   <= 1'b0;
        lowBuf[p] <= '0;
      end else if (loRd[p]) begin
        pend[p] <= 1'b0;
      end else if (hiRd[p] && !pend[p]) begin
        pend[p]   <= 1'b1;
        lowBuf[p] <= cnt[DATA_W-1:0];
      end
    end
    assign loView[p] = pend[p] ? lowBuf[p] : cnt[DATA_W-1:0];
  end

  always_comb begin
    case (addr)
      A_MAIN_HI, A_ALT_HI: rdData = cnt[CNT_W-1:DATA_W];
      A_MAIN_LO:           rdData = loView[0];
      A_ALT_LO:            rdData = loView[1];
      A_STATUS:            rdData = {{(DATA_W-1){1'b0}}, flag};
      A_CTRL:              rdData = ctrlReg;
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/byte_read_timer.sv
module byte_read_timer
  import brt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 2 * DATA_W,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqMaskIn,
  input  logic              haltIn,
  input  logic              waitIn,
  output logic              irqOut
);
  strobe_t           strb;
  logic              flag;
  logic              wrapPulse;
  logic [DATA_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  cnt;

  brt_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .irqMaskIn(irqMaskIn), .wrapPulse(wrapPulse),
    .strb(strb), .flag(flag), .ctrlReg(ctrlReg), .irqOut(irqOut)
  );

  brt_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) dp_i (
    .clk(clk), .rstN(rstN), .haltIn(haltIn), .strb(strb), .addr(addr),
    .flag(flag), .ctrlReg(ctrlReg), .cnt(cnt), .wrapPulse(wrapPulse),
    .rdData(rdData)
  );
endmodule

// File: rtl/brt_checker.sv
module brt_checker
  import brt_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 2 * DATA_W,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'hFFFC
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              haltIn,
  input logic              waitIn,
  input logic              irqMaskIn,
  input logic              irqOut,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag
);
  logic wrLo;
  logic altAccess;
  assign wrLo      = wrEn && (addr == A_MAIN_LO);
  assign altAccess = (rdEn || wrEn) && (addr == A_ALT_HI || addr == A_ALT_LO);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!haltIn && !wrLo) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_WAIT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (waitIn && !haltIn && !wrLo) |=> cnt != $past(cnt)); // R2
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (haltIn && !wrLo) |=> $stable(cnt)); // R3
  AST_LOAD_RESET_VAL: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> cnt == RESET_VAL); // R12
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!haltIn && !wrLo && cnt == {CNT_W{1'b1}}) |=> flag); // R8
  AST_ALT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (flag && altAccess) |=> flag); // R11
  AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irqMaskIn |-> !irqOut); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flag); // R9
endmodule

bind byte_read_timer brt_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_VAL(RESET_VAL)
) chk_i (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
  .haltIn(haltIn), .waitIn(waitIn), .irqMaskIn(irqMaskIn), .irqOut(irqOut),
  .cnt(cnt), .flag(flag)
);

// File: tb/byte_read_timer_tb_top.sv
module byte_read_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqMaskIn = 1'b0;
  logic       haltIn = 1'b0;
  logic       waitIn = 1'b0;
  logic       irqOut;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int mCnt, mFlag, mArmed, mCtrl;
  int mPend[2];
  int mBuf[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_read_timer dut_i (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqMaskIn(irqMaskIn),
    .haltIn(haltIn), .waitIn(waitIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCnt = 'hFFFC; mFlag = 0; mArmed = 0; mCtrl = 0;
    mPend[0] = 0; mPend[1] = 0; mBuf[0] = 0; mBuf[1] = 0;
  endtask

  function automatic int modelRead(input int a);
    case (a)
      0, 2: return (mCnt >> 8) & 'hFF;
      1:    return mPend[0] ? mBuf[0] : (mCnt & 'hFF);
      3:    return mPend[1] ? mBuf[1] : (mCnt & 'hFF);
      4:    return mFlag;
      5:    return mCtrl;
      default: return 0;
    endcase
  endfunction

  // one bus cycle: drive after negedge, compare, advance model, wait to next negedge
  task automatic cyc(input bit rd, input bit wr, input int a, input int wd, input string tag);
    bit wrap, loAcc;
    rdEn = rd; wrEn = wr; addr = 3'(a); wrData = 8'(wd);
    #1;
    if (rd) check({tag, " rdData"}, int'(rdData), modelRead(a));
    check({tag, " irqOut"}, int'(irqOut),
          (mFlag && (mCtrl & 1) && !irqMaskIn) ? 1 : 0);
    wrap  = !haltIn && mCnt == 'hFFFF && !(wr && a == 1);
    loAcc = (rd || wr) && a == 1;
    if (wrap) begin mFlag = 1; mArmed = 0; end
    else if (loAcc) begin if (mArmed) mFlag = 0; mArmed = 0; end
    else if (rd && a == 4 && mFlag) mArmed = 1;
    for (int p = 0; p < 2; p++) begin
      if (rd && a == 2*p + 1) mPend[p] = 0;
      else if (rd && a == 2*p && !mPend[p]) begin mPend[p] = 1; mBuf[p] = mCnt & 'hFF; end
    end
    if (wr && a == 5) mCtrl = wd & 'hFF;
    if (wr && a == 1) mCnt = 'hFFFC;
    else if (!haltIn) mCnt = (mCnt + 1) & 'hFFFF;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    modelReset();
    @(negedge clk);
    doReset();
    // R1: reset state
    check("R1 irqOut", int'(irqOut), 0);
    cyc(1, 0, 1, 0, "R1 count low");
    cyc(1, 0, 4, 0, "R1 flag");
    cyc(1, 0, 5, 0, "R1 ctrl");
    // R8: wrap after reset value
    idle(2, "R2 run");
    cyc(1, 0, 4, 0, "R8 flag set");
    cyc(1, 0, 6, 0, "R13 unused addr");
    // R13 / R9
    cyc(0, 1, 5, 'hA5, "R13 write ctrl");
    cyc(1, 0, 5, 0, "R13 ctrl readback");
    irqMaskIn = 1'b1;
    cyc(0, 0, 0, 0, "R9 masked");
    irqMaskIn = 1'b0;
    cyc(0, 0, 0, 0, "R9 pending fires");
    cyc(0, 1, 5, 'h00, "R9 enable off");
    cyc(0, 0, 0, 0, "R9 disabled");
    cyc(0, 1, 5, 'h01, "R9 enable on");
    // R11 / R10 clear sequence
    cyc(1, 0, 3, 0, "R11 alt low read");
    cyc(1, 0, 4, 0, "R10 arm");
    cyc(1, 0, 3, 0, "R11 alt low while armed");
    cyc(0, 1, 3, 'h12, "R11 alt low write");
    cyc(1, 0, 4, 0, "R11 flag kept");
    cyc(1, 0, 1, 0, "R10 clear by main low");
    cyc(1, 0, 4, 0, "R10 flag cleared");
    // R4 / R5 / R6 coherent reads
    cyc(1, 0, 0, 0, "R4 main high");
    idle(3, "R5 gap");
    cyc(1, 0, 0, 0, "R5 main high again");
    cyc(1, 0, 1, 0, "R5 buffered low");
    cyc(1, 0, 1, 0, "R6 live low");
    // R7 interleaved pairs
    cyc(1, 0, 0, 0, "R7 main high");
    idle(2, "R7 gap");
    cyc(1, 0, 2, 0, "R7 alt high");
    cyc(0, 0, 0, 0, "R7 gap");
    cyc(1, 0, 3, 0, "R7 alt low");
    cyc(1, 0, 1, 0, "R7 main low");
    // R2 / R3 wait and halt
    waitIn = 1'b1;
    idle(3, "R2 wait");
    cyc(1, 0, 1, 0, "R2 count under wait");
    waitIn = 1'b0;
    haltIn = 1'b1;
    idle(4, "R3 halt");
    cyc(1, 0, 1, 0, "R3 frozen low");
    cyc(1, 0, 0, 0, "R3 frozen high");
    haltIn = 1'b0;
    idle(2, "R3 resume");
    cyc(1, 0, 1, 0, "R3 resumed");
    // R12 load and status read with flag clear
    cyc(0, 1, 1, 'h55, "R12 write main low");
    cyc(1, 0, 1, 0, "R12 loaded");
    cyc(1, 0, 4, 0, "R10 status with flag clear");
    idle(3, "R8 wrap");
    cyc(1, 0, 1, 0, "R10 low without arm");
    cyc(1, 0, 4, 0, "R10 flag still set");
    cyc(0, 1, 1, 0, "R10 clear by write");
    cyc(1, 0, 4, 0, "R10 cleared by write");
    idle(4, "R8 wrap again");
    cyc(1, 0, 4, 0, "R10 arm before long run");
    idle(65540, "R2 full period");
    cyc(1, 0, 1, 0, "R10 wrap between steps");
    cyc(1, 0, 4, 0, "R10 flag kept after wrap");
    // R3 reset during halt
    haltIn = 1'b1;
    doReset();
    idle(3, "R3 halted after reset");
    cyc(1, 0, 1, 0, "R3 reset during halt low");
    cyc(1, 0, 0, 0, "R3 reset during halt high");
    haltIn = 1'b0;
    cyc(0, 0, 0, 0, "R3 restart");
    cyc(1, 0, 1, 0, "R3 restarted");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule